// File: doc/BRIEF.md
# Key-Protected Watchdog Timer

This block is a watchdog timer controlled through four 32-bit word registers. Each register has a fixed role: mode, counter control, restart and status. Software must put a register-specific access key in the upper bits of every mode or counter-control write. A write without the correct key leaves the register unchanged.

Once the watchdog is enabled, a prescaled down-counter counts toward zero. Software keeps the system alive by writing one exact restart word. That write reloads the counter from a 12-bit reload field, which is scaled by a power of two. If the counter reaches zero first, a sticky expiry flag sets. The block can then raise a level interrupt, a reset pulse of selectable length, or both. No command exists that forces an expiry; a timeout happens only when the counter runs down.

Top module: `keywdt`

## Requirements
- R1: After reset every register reads zero, both outputs are low, and the counter holds 2^LOW_W-1.
- R2: A write to offset 0x0 takes effect only if bits 23:12 equal 0xABC; otherwise it is ignored. Its fields are: bit 0 counter enable, bit 1 reset-output enable, bit 2 interrupt enable, bits 5:4 pulse-length code.
- R3: A write to offset 0x4 takes effect only if bits 25:14 equal 0x248, which appears as 0x00920000 in the word; otherwise it is ignored. Bits 13:2 hold the reload field and bits 1:0 hold the prescaler select. Bits 31:26 are ignored.
- R4: Reads return the stored fields with the key bits as zero. Offset 0x8 reads zero. Offset 0xC reads the expiry flag in bit 0, and writes to 0xC are ignored.
- R5: Writing exactly 0x00001999 to offset 0x8 does three things. It loads the counter with reload*2^LOW_W + 2^LOW_W-1, clears the prescaler and clears the expiry flag. Any other value written there has no effect.
- R6: Prescaler select values 0, 1, 2 and 3 divide by 8, 64, 512 and 4096. After a restart with count C and divide D, the expiry flag reads 1 exactly C*D enabled clock edges later and reads 0 one edge earlier.
- R7: The expiry flag sets when the counter reaches zero. It stays set until the next valid restart, and the counter holds at zero meanwhile.
- R8: The interrupt output is high exactly while the expiry flag is set and interrupts are enabled.
- R9: When the reset-output enable is set, each expiry produces exactly one reset pulse. Pulse-length codes 0, 1, 2 and 3 give 2, 4, 8 and 16 clock cycles.
- R10: While the counter enable is clear, the prescaler and counter hold their values. Counting resumes from those values once the enable is set again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Register access strobe |
| bus_we | input | 1 | Write qualifier for the access |
| bus_addr | input | 4 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr |
| wdt_rst | output | 1 | Reset pulse on expiry |
| wdt_irq | output | 1 | Level interrupt on expiry |

## Verification
The hardest case to reach from the ports is a countdown interrupted by a pause: the enable is cleared partway through and set again later, and expiry must still land on the exact edge. The stimulus counts enabled edges, and that count includes the edge where the disabling write lands but not the edge where the re-enabling write lands. It then checks the expiry flag one edge before and exactly at the predicted edge. The counter is never visible at the ports. For that reason the bench shrinks the low counter field through its parameter, so that every prescaler setting expires within the run. Exact timing at each setting then shows both the divide ratio and the reload scaling.

// File: rtl/keywdt.sv
module keywdt #(
  parameter int LOW_W = 12
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_sel,
  input  logic        bus_we,
  input  logic [3:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        wdt_rst,
  output logic        wdt_irq
);
  localparam int RLD_W = 12;
  localparam int CNT_W = RLD_W + LOW_W;
  localparam int PS_W  = 12;
  localparam logic [11:0] MODE_KEY = 12'hABC;
  localparam logic [11:0] CTRL_KEY = 12'h248;
  localparam logic [31:0] KICK_VAL = 32'h0000_1999;

  logic             en, rst_en, irq_en;
  logic [1:0]       len;
  logic [RLD_W-1:0] crv;
  logic [1:0]       psel;
  logic [CNT_W-1:0] count;
  logic [PS_W-1:0]  pcnt;
  logic [PS_W-1:0]  div_last;
  logic             expired;
  logic [3:0]       rst_cnt;

  wire wr      = bus_sel & bus_we;
  wire mode_wr = wr && bus_addr[3:2] == 2'd0 && bus_wdata[23:12] == MODE_KEY;
  wire ctrl_wr = wr && bus_addr[3:2] == 2'd1 && bus_wdata[25:14] == CTRL_KEY;
  wire kick    = wr && bus_addr[3:2] == 2'd2 && bus_wdata == KICK_VAL;

  always_comb begin
    case (psel)
      2'd0:    div_last = PS_W'(7);
      2'd1:    div_last = PS_W'(63);
      2'd2:    div_last = PS_W'(511);
      default: div_last = PS_W'(4095);
    endcase
  end

  wire tick      = en && (pcnt >= div_last);
  wire expire_ev = !kick && tick && (count == CNT_W'(1));
  wire [3:0] len_last = (4'd2 << len) - 4'd1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en <= 1'b0; rst_en <= 1'b0; irq_en <= 1'b0; len <= 2'd0;
      crv <= '0; psel <= 2'd0;
    end else begin
      if (mode_wr) begin
        en     <= bus_wdata[0];
        rst_en <= bus_wdata[1];
        irq_en <= bus_wdata[2];
        len    <= bus_wdata[5:4];
      end
      if (ctrl_wr) begin
        crv  <= bus_wdata[13:2];
        psel <= bus_wdata[1:0];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count   <= {{RLD_W{1'b0}}, {LOW_W{1'b1}}};
      pcnt    <= '0;
      expired <= 1'b0;
    end else if (kick) begin
      count   <= {crv, {LOW_W{1'b1}}};
      pcnt    <= '0;
      expired <= 1'b0;
    end else if (en) begin
      if (tick) begin
        pcnt <= '0;
        if (count != '0) count <= count - CNT_W'(1);
        if (expire_ev) expired <= 1'b1;
      end else begin
        pcnt <= pcnt + PS_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wdt_rst <= 1'b0;
      rst_cnt <= 4'd0;
    end else if (expire_ev && rst_en) begin
      wdt_rst <= 1'b1;
      rst_cnt <= len_last;
    end else if (wdt_rst) begin
      if (rst_cnt == 4'd0) wdt_rst <= 1'b0;
      else rst_cnt <= rst_cnt - 4'd1;
    end
  end

  assign wdt_irq = expired & irq_en;

  always_comb begin
    case (bus_addr[3:2])
      2'd0:    bus_rdata = {26'd0, len, 1'b0, irq_en, rst_en, en};
      2'd1:    bus_rdata = {18'd0, crv, psel};
      2'd2:    bus_rdata = 32'd0;
      default: bus_rdata = {31'd0, expired};
    endcase
  end
endmodule

module keywdt_chk #(
  parameter int LOW_W = 12
) (
  input logic                clk,
  input logic                rst_n,
  input logic                bus_sel,
  input logic                bus_we,
  input logic [3:0]          bus_addr,
  input logic [31:0]         bus_wdata,
  input logic                wdt_rst,
  input logic                wdt_irq,
  input logic                en,
  input logic                expired,
  input logic [11:0]         crv,
  input logic [1:0]          psel,
  input logic [2:0]          mode_bits,
  input logic [1:0]          len,
  input logic [12+LOW_W-1:0] count,
  input logic [11:0]         pcnt
);
  logic [4:0] run;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run <= 5'd0;
    else if (wdt_rst) run <= (run == 5'd31) ? run : run + 5'd1;
    else run <= 5'd0;
  end

  wire wr        = bus_sel && bus_we;
  wire good_kick = wr && bus_addr[3:2] == 2'd2 && bus_wdata == 32'h1999;
  wire bad_mode  = wr && bus_addr[3:2] == 2'd0 && bus_wdata[23:12] != 12'hABC;
  wire bad_ctrl  = wr && bus_addr[3:2] == 2'd1 && bus_wdata[25:14] != 12'h248;

  assert_pulse_max_R9: assert property (@(posedge clk) disable iff (!rst_n)
    run <= 5'd16);
  assert_pulse_on_expiry_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wdt_rst) |-> $rose(expired));
  assert_flag_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (expired && !good_kick) |=> expired);
  assert_mode_key_R2: assert property (@(posedge clk) disable iff (!rst_n)
    bad_mode |=> ($stable(mode_bits) && $stable(len)));
  assert_ctrl_key_R3: assert property (@(posedge clk) disable iff (!rst_n)
    bad_ctrl |=> ($stable(crv) && $stable(psel)));
  assert_halt_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !good_kick) |=> ($stable(count) && $stable(pcnt)));
  assert_irq_needs_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_irq |-> expired);
endmodule

bind keywdt keywdt_chk #(.LOW_W(LOW_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .wdt_rst(wdt_rst),
  .wdt_irq(wdt_irq), .en(en), .expired(expired), .crv(crv), .psel(psel),
  .mode_bits({irq_en, rst_en, en}), .len(len), .count(count), .pcnt(pcnt)
);

// File: tb/tb_keywdt.sv
module tb_keywdt;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0, bus_we = 1'b0;
  logic [3:0]  bus_addr = 4'h0;
  logic [31:0] bus_wdata = 32'h0;
  logic [31:0] bus_rdata;
  logic        wdt_rst, wdt_irq;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  keywdt #(.LOW_W(4)) dut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .wdt_rst(wdt_rst), .wdt_irq(wdt_irq)
  );

  localparam logic [67:0] VEC [0:8] = '{
    {4'h0, 32'h00ABD007, 32'h0000_0000},
    {4'h0, 32'hFFABC037, 32'h0000_0037},
    {4'h4, 32'h00930016, 32'h0000_0000},
    {4'h4, 32'h00920016, 32'h0000_0016},
    {4'h4, 32'hFC923FFD, 32'h0000_3FFD},
    {4'h8, 32'h00001999, 32'h0000_0000},
    {4'hC, 32'hFFFFFFFF, 32'h0000_0000},
    {4'h0, 32'h00ABC000, 32'h0000_0000},
    {4'h4, 32'h00920000, 32'h0000_0000}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic adv(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic expect_expiry(input string req, input int t);
    logic [31:0] v;
    adv(t - 1);
    rd(4'hC, v); check({req, " one edge early"}, v, 32'd0);
    adv(1);
    rd(4'hC, v); check({req, " on time"}, v, 32'd1);
  endtask

  task automatic pulse_len(output int n);
    n = 0;
    while (wdt_rst && n < 40) begin n++; adv(1); end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (199000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected completion");
      finish_run();
    end
  end

  initial begin
    logic [31:0] v;
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    adv(1);

    // R1 reset state
    for (int a = 0; a < 4; a++) begin
      rd(4'(a * 4), v); check("R1 register reset", v, 32'd0);
    end
    check("R1 rst low", {31'd0, wdt_rst}, 32'd0);
    check("R1 irq low", {31'd0, wdt_irq}, 32'd0);

    // R2 R3 R4 key checks and readback table
    for (int i = 0; i < 9; i++) begin
      wr(VEC[i][67:64], VEC[i][63:32]);
      rd(VEC[i][67:64], v);
      check("R2/R3/R4 table", v, VEC[i][31:0]);
    end

    // R6 R8 R9: crv 0, divide 8 -> 15*8 = 120 edges, 16-cycle pulse
    wr(4'h4, 32'h00920000);
    wr(4'h0, 32'h00ABC037);
    wr(4'h8, 32'h00001999);
    check("R8 irq low before expiry", {31'd0, wdt_irq}, 32'd0);
    expect_expiry("R6 div8", 120);
    check("R8 irq high on expiry", {31'd0, wdt_irq}, 32'd1);
    pulse_len(n); check("R9 pulse len code3", n, 16);
    adv(300);
    rd(4'hC, v); check("R7 flag sticky", v, 32'd1);
    check("R9 single pulse", {31'd0, wdt_rst}, 32'd0);

    // R5 wrong restart value ignored, then valid restart clears
    wr(4'h8, 32'h00001998);
    rd(4'hC, v); check("R5 bad kick keeps flag", v, 32'd1);
    check("R8 irq still high", {31'd0, wdt_irq}, 32'd1);
    wr(4'h8, 32'h00001999);
    rd(4'hC, v); check("R5 kick clears flag", v, 32'd0);
    check("R8 irq cleared", {31'd0, wdt_irq}, 32'd0);
    adv(59);
    wr(4'h8, 32'h00011999);
    expect_expiry("R5 bad kick mid-run no reload", 60);
    adv(20);

    // R9 pulse lengths for codes 0..2
    for (int c = 0; c < 3; c++) begin
      wr(4'h0, 32'h00ABC007 | (32'(c) << 4));
      wr(4'h8, 32'h00001999);
      expect_expiry("R9 expiry", 120);
      pulse_len(n); check("R9 pulse len", n, 2 << c);
    end

    // R8 R9 outputs disabled
    wr(4'h0, 32'h00ABC001);
    wr(4'h8, 32'h00001999);
    expect_expiry("R7 expiry outputs off", 120);
    check("R8 irq masked", {31'd0, wdt_irq}, 32'd0);
    check("R9 no pulse when disabled", {31'd0, wdt_rst}, 32'd0);

    // R10 halt and resume: 50 edges, pause, 70 more edges
    wr(4'h0, 32'h00ABC005);
    wr(4'h8, 32'h00001999);
    adv(49);
    wr(4'h0, 32'h00ABC004);
    adv(199);
    rd(4'hC, v); check("R10 no expiry while halted", v, 32'd0);
    wr(4'h0, 32'h00ABC005);
    expect_expiry("R10 resume", 70);
    check("R8 irq after resume", {31'd0, wdt_irq}, 32'd1);

    // R6 other prescalers, crv 0 -> count 15
    for (int s = 1; s < 4; s++) begin
      wr(4'h4, 32'h00920000 | 32'(s));
      wr(4'h8, 32'h00001999);
      expect_expiry("R6 prescaler", 15 * (8 << (3 * s)));
    end

    // R5 reload scaling: crv 2 -> 2*16+15 = 47, divide 8
    wr(4'h4, 32'h00920008);
    wr(4'h8, 32'h00001999);
    expect_expiry("R5 reload scale", 376);

    done = 1;
    finish_run();
  end
endmodule